// File: doc/BRIEF.md
# TDM Multichannel Transmit Slot Selector

This block drives the transmit side of a time-division-multiplexed serial link. A frame begins with a frame-sync pulse and is divided into a fixed number of channel slots, each a fixed number of bit clocks long. At the start of every slot the block decides two things. First, whether the channel is enabled, which means the word waiting in the holding register is copied into the shift register. Second, whether the channel is unmasked, which means the data pin is driven during the slot. In a masked or disabled slot the pin is left high-impedance through a low output enable.

A two-bit mode code picks one of four policies. The policies combine a per-channel transmit enable vector with a per-channel receive enable vector. In the symmetric mode, the receive vector chooses the channels that are enabled and the transmit vector chooses which of those are driven. The mode code and both vectors are captured only at frame sync. Software loads words through a write strobe and watches a ready flag. If an enabled slot arrives with no fresh word, the previous word is sent again and a sticky underflow flag is raised.

Top module: `tdm_tx_chan_sel`

## Requirements
- R1: A clock edge with `fsync` high starts slot 0. Each slot lasts SLOT_BITS (8) clocks, and slot n begins at the edge SLOT_BITS·n after the sync edge. After NUM_CH (4) slots, `sd_oe` stays low until the next sync.
- R2: Mode code 2'b00 enables and drives every channel, so each slot copies the holding word and `sd_oe` is high for the whole frame.
- R3: Mode code 2'b01 enables and drives only the channels whose transmit-enable bit is set. Other slots make no copy and keep `sd_oe` low.
- R4: Mode code 2'b10 copies the holding word in every slot but drives `sd_oe` only in slots whose transmit-enable bit is set.
- R5: Mode code 2'b11 enables the channels whose receive-enable bit is set and drives only those whose transmit-enable bit is also set.
- R6: Bit n of each enable vector governs channel n (slot n). A value of 4'b1010 selects channels 1 and 3.
- R7: `tx_ready` is low from the edge after a `wr_strobe` until a copy into the shift register at the start of an enabled slot. It then rises on the edge of that slot start.
- R8: While `sd_oe` is high, `sd_out` carries the shift word most significant bit first, one bit per clock starting at the slot-start edge. While `sd_oe` is low, `sd_out` is 0.
- R9: An enabled slot that starts with no unsent word in the holding register retransmits the previous shift word. It also sets `underflow`, which stays high until reset.
- R10: The mode code and both enable vectors take effect only at a sync edge. Changing them within a frame does not alter that frame.
- R11: After reset `tx_ready` is 1, and `sd_oe`, `sd_out` and `underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, high for one clock at the first bit of a frame |
| mode_sel | input | 2 | Channel enable policy code |
| tx_chan_en | input | NUM_CH | Per-channel transmit enable vector |
| rx_chan_en | input | NUM_CH | Per-channel receive enable vector |
| wr_strobe | input | 1 | Loads `wr_data` into the holding register |
| wr_data | input | SLOT_BITS | Word for the holding register |
| sd_out | output | 1 | Serial transmit data |
| sd_oe | output | 1 | Data pin output enable |
| tx_ready | output | 1 | Holding register may be written |
| underflow | output | 1 | Sticky: an enabled slot found no new word |

## Verification
The bench counts driven clocks and ready-flag rises per frame for each mode. A design that mixed up the copy and drive decisions would show a copy count that disagrees with the drive count, for example in mode 2'b10. Changing the inputs in the middle of a frame catches a design that decodes the live inputs instead of the captured ones, because its driven-clock count shifts. A frame run without new writes catches two faults: a design that sends stale or zeroed data in the later slots, and a design that clears underflow on its own. Reset applied after underflow confirms the flag comes back low.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;

    typedef enum logic [1:0] {
        SEL_ALL     = 2'b00,
        SEL_TXONLY  = 2'b01,
        SEL_ALLMASK = 2'b10,
        SEL_RXGATE  = 2'b11
    } sel_mode_e;

    // Whether the holding word is copied into the shift register for a slot
    function automatic logic chan_enabled(sel_mode_e m, logic tx_bit, logic rx_bit);
        logic r;
        case (m)
            SEL_ALL:     r = 1'b1;
            SEL_TXONLY:  r = tx_bit;
            SEL_ALLMASK: r = 1'b1;
            SEL_RXGATE:  r = rx_bit;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

    // Whether an enabled slot drives the pin
    function automatic logic chan_unmasked(sel_mode_e m, logic tx_bit, logic rx_bit);
        logic r;
        case (m)
            SEL_ALL:     r = 1'b1;
            SEL_TXONLY:  r = tx_bit;
            SEL_ALLMASK: r = tx_bit;
            SEL_RXGATE:  r = rx_bit & tx_bit;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int NUM_CH    = 4,
    parameter int SLOT_BITS = 8,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BIT_W    = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             slot_start,
    output logic             frame_end,
    output logic [CH_W-1:0]  start_ch,
    output logic [BIT_W-1:0] bit_idx
);

    localparam logic [CH_W-1:0]  LAST_SLOT = CH_W'(NUM_CH - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic [CH_W-1:0]  slot;
        logic [BIT_W-1:0] bitc;
        logic             in_frame;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic slot_done;

    always_comb begin
        tmr_d      = tmr_q;
        slot_done  = tmr_q.in_frame && (tmr_q.bitc == LAST_BIT);
        slot_start = 1'b0;
        frame_end  = 1'b0;
        start_ch   = '0;
        if (fsync) begin
            slot_start     = 1'b1;
            start_ch       = '0;
            tmr_d.slot     = '0;
            tmr_d.bitc     = '0;
            tmr_d.in_frame = 1'b1;
        end else if (slot_done) begin
            tmr_d.bitc = '0;
            if (tmr_q.slot == LAST_SLOT) begin
                frame_end      = 1'b1;
                tmr_d.in_frame = 1'b0;
            end else begin
                slot_start = 1'b1;
                start_ch   = tmr_q.slot + 1'b1;
                tmr_d.slot = tmr_q.slot + 1'b1;
            end
        end else if (tmr_q.in_frame) begin
            tmr_d.bitc = tmr_q.bitc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign bit_idx = tmr_q.bitc;

endmodule

// File: rtl/tdm_cfg_snap.sv
module tdm_cfg_snap #(
    parameter int NUM_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fsync,
    input  logic [1:0]            mode_in,
    input  logic [NUM_CH-1:0]     tx_in,
    input  logic [NUM_CH-1:0]     rx_in,
    output tdm_sel_pkg::sel_mode_e mode_eff,
    output logic [NUM_CH-1:0]     tx_eff,
    output logic [NUM_CH-1:0]     rx_eff
);

    import tdm_sel_pkg::*;

    typedef struct packed {
        sel_mode_e         mode;
        logic [NUM_CH-1:0] tx;
        logic [NUM_CH-1:0] rx;
    } cfg_t;

    cfg_t cfg_d, cfg_q, cfg_live;

    always_comb begin
        cfg_live.mode = sel_mode_e'(mode_in);
        cfg_live.tx   = tx_in;
        cfg_live.rx   = rx_in;
        cfg_d         = fsync ? cfg_live : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // The sync edge itself already uses the new settings
    assign mode_eff = cfg_d.mode;
    assign tx_eff   = cfg_d.tx;
    assign rx_eff   = cfg_d.rx;

endmodule

// File: rtl/tdm_chan_policy.sv
module tdm_chan_policy #(
    parameter int NUM_CH = 4
) (
    input  tdm_sel_pkg::sel_mode_e mode,
    input  logic [NUM_CH-1:0]      tx_vec,
    input  logic [NUM_CH-1:0]      rx_vec,
    output logic [NUM_CH-1:0]      en_vec,
    output logic [NUM_CH-1:0]      unm_vec
);

    import tdm_sel_pkg::*;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            en_vec[c]  = chan_enabled(mode, tx_vec[c], rx_vec[c]);
            unm_vec[c] = chan_unmasked(mode, tx_vec[c], rx_vec[c]);
        end
    end

endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath #(
    parameter int SLOT_BITS = 8,
    localparam int BIT_W    = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_strobe,
    input  logic [SLOT_BITS-1:0] wr_data,
    input  logic                 slot_start,
    input  logic                 frame_end,
    input  logic                 cur_en,
    input  logic                 cur_unm,
    input  logic [BIT_W-1:0]     bit_idx,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 tx_ready,
    output logic                 underflow
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic [SLOT_BITS-1:0] hold;
        logic                 full;
        logic [SLOT_BITS-1:0] shift;
        logic                 oe;
        logic                 uf;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (slot_start) begin
            dp_d.oe = cur_en & cur_unm;
            if (cur_en) begin
                if (dp_q.full) begin
                    dp_d.shift = dp_q.hold;
                    dp_d.full  = 1'b0;
                end else begin
                    dp_d.uf = 1'b1;
                end
            end
        end else if (frame_end) begin
            dp_d.oe = 1'b0;
        end
        // A write on a copy edge lands after the copy has taken the old word
        if (wr_strobe) begin
            dp_d.hold = wr_data;
            dp_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    // Word stays intact across the slot so an underflow can resend it
    assign sd_out    = dp_q.oe & dp_q.shift[LAST_BIT - bit_idx];
    assign sd_oe     = dp_q.oe;
    assign tx_ready  = ~dp_q.full;
    assign underflow = dp_q.uf;

endmodule

// File: rtl/tdm_tx_chan_sel.sv
module tdm_tx_chan_sel #(
    parameter int NUM_CH    = 4,
    parameter int SLOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic [1:0]           mode_sel,
    input  logic [NUM_CH-1:0]    tx_chan_en,
    input  logic [NUM_CH-1:0]    rx_chan_en,
    input  logic                 wr_strobe,
    input  logic [SLOT_BITS-1:0] wr_data,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 tx_ready,
    output logic                 underflow
);

    import tdm_sel_pkg::*;

    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    logic              slot_start;
    logic              frame_end;
    logic [CH_W-1:0]   start_ch;
    logic [BIT_W-1:0]  bit_idx;
    sel_mode_e         eff_mode;
    logic [NUM_CH-1:0] eff_tx;
    logic [NUM_CH-1:0] eff_rx;
    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] unm_vec;
    logic              cur_en;
    logic              cur_unm;

    tdm_slot_timer #(.NUM_CH(NUM_CH), .SLOT_BITS(SLOT_BITS)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .slot_start (slot_start),
        .frame_end  (frame_end),
        .start_ch   (start_ch),
        .bit_idx    (bit_idx)
    );

    tdm_cfg_snap #(.NUM_CH(NUM_CH)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .mode_in  (mode_sel),
        .tx_in    (tx_chan_en),
        .rx_in    (rx_chan_en),
        .mode_eff (eff_mode),
        .tx_eff   (eff_tx),
        .rx_eff   (eff_rx)
    );

    tdm_chan_policy #(.NUM_CH(NUM_CH)) i_policy (
        .mode    (eff_mode),
        .tx_vec  (eff_tx),
        .rx_vec  (eff_rx),
        .en_vec  (en_vec),
        .unm_vec (unm_vec)
    );

    assign cur_en  = en_vec[start_ch];
    assign cur_unm = unm_vec[start_ch];

    tdm_tx_datapath #(.SLOT_BITS(SLOT_BITS)) i_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_strobe  (wr_strobe),
        .wr_data    (wr_data),
        .slot_start (slot_start),
        .frame_end  (frame_end),
        .cur_en     (cur_en),
        .cur_unm    (cur_unm),
        .bit_idx    (bit_idx),
        .sd_out     (sd_out),
        .sd_oe      (sd_oe),
        .tx_ready   (tx_ready),
        .underflow  (underflow)
    );

endmodule

// File: rtl/tdm_tx_chan_sel_chk.sv
module tdm_tx_chan_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_strobe,
    input logic       slot_start,
    input logic       frame_end,
    input logic       cur_en,
    input logic       cur_unm,
    input logic [1:0] eff_mode,
    input logic       sd_out,
    input logic       sd_oe,
    input logic       tx_ready,
    input logic       underflow
);

    AST_READY_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !tx_ready); // R7

    AST_READY_RISES_AT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(slot_start && cur_en)); // R7

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R9

    AST_QUIET_PIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out); // R8

    AST_MASKED_SLOT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && !(cur_en && cur_unm)) |=> !sd_oe); // R3

    AST_ALL_MODE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && eff_mode == 2'b00) |=> sd_oe); // R2

    AST_FRAME_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !sd_oe); // R1

endmodule

bind tdm_tx_chan_sel tdm_tx_chan_sel_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_strobe  (wr_strobe),
    .slot_start (slot_start),
    .frame_end  (frame_end),
    .cur_en     (cur_en),
    .cur_unm    (cur_unm),
    .eff_mode   (eff_mode),
    .sd_out     (sd_out),
    .sd_oe      (sd_oe),
    .tx_ready   (tx_ready),
    .underflow  (underflow)
);

// File: tb/test_tdm_tx_chan_sel.sv
`timescale 1ns/1ps
module test_tdm_tx_chan_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [3:0] tx_chan_en = 4'b0000;
    logic [3:0] rx_chan_en = 4'b0000;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sd_out, sd_oe, tx_ready, underflow;

    int errors = 0;
    int checks = 0;
    logic [7:0] word_gen = 8'h5A;

    always #2.5 clk = ~clk;

    tdm_tx_chan_sel i_tdm_tx_chan_sel (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .mode_sel(mode_sel),
        .tx_chan_en(tx_chan_en), .rx_chan_en(rx_chan_en),
        .wr_strobe(wr_strobe), .wr_data(wr_data),
        .sd_out(sd_out), .sd_oe(sd_oe), .tx_ready(tx_ready), .underflow(underflow)
    );

    // Behavioural reference model
    int         m_slot, m_bit;
    bit         m_in;
    int         m_mode;
    bit [3:0]   m_tx, m_rx;
    bit [7:0]   m_hold, m_shift;
    bit         m_full, m_oe, m_uf;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_slot = 0; m_bit = 0; m_in = 0; m_mode = 0; m_tx = 0; m_rx = 0;
            m_hold = 0; m_shift = 0; m_full = 0; m_oe = 0; m_uf = 0;
        end else begin
            int  ch, md;
            bit  start, fend, en, unm;
            bit [3:0] tv, rv;
            if (fsync) begin
                m_mode = mode_sel; m_tx = tx_chan_en; m_rx = rx_chan_en;
            end
            md = m_mode; tv = m_tx; rv = m_rx;
            start = 0; fend = 0; ch = 0;
            if (fsync) begin
                start = 1; ch = 0;
            end else if (m_in && m_bit == 7) begin
                if (m_slot == 3) fend = 1;
                else begin start = 1; ch = m_slot + 1; end
            end
            case (md)
                0: begin en = 1;      unm = 1; end
                1: begin en = tv[ch]; unm = tv[ch]; end
                2: begin en = 1;      unm = tv[ch]; end
                default: begin en = rv[ch]; unm = rv[ch] && tv[ch]; end
            endcase
            if (start) begin
                m_oe = en && unm;
                if (en) begin
                    if (m_full) begin m_shift = m_hold; m_full = 0; end
                    else m_uf = 1;
                end
            end else if (fend) m_oe = 0;
            if (wr_strobe) begin m_hold = wr_data; m_full = 1; end
            if (fsync) begin m_in = 1; m_slot = 0; m_bit = 0; end
            else if (start) begin m_slot = ch; m_bit = 0; end
            else if (fend) begin m_in = 0; m_bit = 0; end
            else if (m_in) m_bit = m_bit + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e_sd;
        e_sd = m_oe ? m_shift[7 - m_bit] : 1'b0;
        chk(sd_out === e_sd, "R8 sd_out", sd_out, e_sd);
        chk(sd_oe === m_oe, "R1 sd_oe", sd_oe, m_oe);
        chk(tx_ready === !m_full, "R7 tx_ready", tx_ready, !m_full);
        chk(underflow === m_uf, "R9 underflow", underflow, m_uf);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (rst_n) compare();
    endtask

    task automatic run_frame(input logic [1:0] md, input logic [3:0] tv, input logic [3:0] rv,
                             input bit feed, input bit chg, input logic [1:0] md2,
                             output int oe_cnt, output int rises, output logic [7:0] last_bits,
                             output bit oe_after);
        bit prev_rdy;
        oe_cnt = 0; rises = 0; last_bits = 0; oe_after = 0;
        mode_sel = md; tx_chan_en = tv; rx_chan_en = rv;
        fsync = 1'b1;
        wr_strobe = 1'b0;
        prev_rdy = tx_ready;
        for (int k = 0; k < 40; k++) begin
            tick();
            fsync = 1'b0;
            if (chg && k == 3) begin
                mode_sel = md2; tx_chan_en = ~tv; rx_chan_en = ~rv;
            end
            if (k < 32) begin
                if (sd_oe) oe_cnt++;
                if (tx_ready && !prev_rdy) rises++;
            end
            if (k >= 24 && k < 32) last_bits = {last_bits[6:0], sd_out};
            if (k == 32) oe_after = sd_oe;
            prev_rdy = tx_ready;
            if (feed && tx_ready) begin
                word_gen = word_gen * 8'd5 + 8'd3;
                wr_strobe = 1'b1; wr_data = word_gen;
            end else wr_strobe = 1'b0;
        end
        wr_strobe = 1'b0;
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int oe_c, rs;
        logic [7:0] lb;
        bit oa;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset values
        chk(tx_ready === 1'b1, "R11 tx_ready", tx_ready, 1);
        chk(sd_oe === 1'b0, "R11 sd_oe", sd_oe, 0);
        chk(sd_out === 1'b0, "R11 sd_out", sd_out, 0);
        chk(underflow === 1'b0, "R11 underflow", underflow, 0);
        rst_n = 1'b1;
        tick();

        // R7 write drops ready on the next edge
        wr_strobe = 1'b1; wr_data = 8'hC3;
        tick();
        wr_strobe = 1'b0;
        chk(tx_ready === 1'b0, "R7 ready after write", tx_ready, 0);
        tick(); tick();

        run_frame(2'b00, 4'b0000, 4'b0000, 1, 0, 2'b00, oe_c, rs, lb, oa);
        chk(oe_c == 32, "R2 driven clocks", oe_c, 32);
        chk(rs == 4, "R2 copies", rs, 4);
        chk(oa == 1'b0, "R1 pin released after last slot", oa, 0);

        // R6: 4'b1010 picks channels 1 and 3
        run_frame(2'b01, 4'b1010, 4'b0000, 1, 0, 2'b00, oe_c, rs, lb, oa);
        chk(oe_c == 16, "R3 driven clocks", oe_c, 16);
        chk(rs == 2, "R3 copies", rs, 2);
        run_frame(2'b01, 4'b0001, 4'b0000, 1, 0, 2'b00, oe_c, rs, lb, oa);
        chk(oe_c == 8, "R6 single channel 0", oe_c, 8);

        run_frame(2'b10, 4'b1010, 4'b0000, 1, 0, 2'b00, oe_c, rs, lb, oa);
        chk(oe_c == 16, "R4 driven clocks", oe_c, 16);
        chk(rs == 4, "R4 copies", rs, 4);

        run_frame(2'b11, 4'b1000, 4'b1010, 1, 0, 2'b00, oe_c, rs, lb, oa);
        chk(oe_c == 8, "R5 driven clocks", oe_c, 8);
        chk(rs == 2, "R5 copies", rs, 2);

        // R10: inputs changed inside the frame are ignored until next sync
        run_frame(2'b01, 4'b0001, 4'b0000, 1, 1, 2'b00, oe_c, rs, lb, oa);
        chk(oe_c == 8, "R10 mid-frame change ignored", oe_c, 8);
        run_frame(2'b00, 4'b0000, 4'b0000, 1, 0, 2'b00, oe_c, rs, lb, oa);
        chk(oe_c == 32, "R10 change applied at sync", oe_c, 32);
        tick();

        // R9: one pending word, no further writes
        run_frame(2'b00, 4'b0000, 4'b0000, 0, 0, 2'b00, oe_c, rs, lb, oa);
        chk(rs == 1, "R9 single copy", rs, 1);
        chk(lb == word_gen, "R9 last slot resends word", lb, word_gen);
        chk(underflow === 1'b1, "R9 underflow set", underflow, 1);
        repeat (5) tick();
        chk(underflow === 1'b1, "R9 underflow sticky", underflow, 1);

        rst_n = 1'b0;
        #1;
        chk(underflow === 1'b0, "R11 underflow cleared", underflow, 0);
        chk(tx_ready === 1'b1, "R11 ready after reset", tx_ready, 1);
        tick();
        rst_n = 1'b1;
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule